// File: doc/BRIEF.md
# PCI Read Initiator Sequencer

This block is the bus-master side of a 32-bit PCI interface, limited to memory and I/O reads. A local client presents an address, a four-bit bus command, active-low byte enables and a burst flag. The sequencer then runs a read transaction on the shared bus and returns each captured dword with a one-clock done strobe. It runs the transaction on a fixed per-clock plan: an address clock, then a turnaround clock, then data phases that complete on the first edge where both sides are ready.

A request with the burst flag clear moves one dword. A request with the flag set moves two back-to-back dwords. The tri-state pads sit outside the block. Every bus signal therefore comes out as a registered value plus a registered output enable, and the sampled bus values come in on separate inputs. A small counter watches for a target claim. If no target answers, the transaction ends as a master abort with all-ones data and an error flag.

Top module: `pci_rd_initiator`

## Requirements
- R1: After reset, and during reset, `busy_o`, `done_o` and every output enable (`ad_oe_o`, `cbe_oe_o`, `frame_oe_o`, `irdy_oe_o`) are 0, and `frame_n_o` and `irdy_n_o` are 1.
- R2: When `req_valid_i` is high at a rising edge while the block is idle, the outputs after that edge show the address clock: `frame_n_o`=0, `ad_oe_o`=1, `ad_o` equal to the request address, `cbe_n_o` equal to the request command, and `busy_o`=1.
- R3: In the clock after the address clock, `ad_oe_o`=0, `cbe_n_o` carries the request's active-low byte enables, and `irdy_n_o`=0. `ad_oe_o` is never 1 while `irdy_n_o` is 0.
- R4: For a single-dword read (`req_burst_i`=0), `frame_n_o` is 0 for exactly one clock, the address clock.
- R5: A data phase completes on an edge that samples `irdy_n_o`, `trdy_n_i` and `devsel_n_i` all 0. The value sampled on `ad_i` at that edge appears on `rd_data_o`, with `done_o`=1 and `err_o`=0, for the following clock.
- R6: While the target holds `trdy_n_i` at 1 (wait states), `irdy_n_o` stays 0 and `done_o` stays 0.
- R7: For a burst (`req_burst_i`=1), `frame_n_o` stays 0 through the first data phase and goes to 1 after the edge that completes it, while `irdy_n_o` stays 0. Two done strobes follow, and only the second has `rd_last_o`=1.
- R8: After the final transfer, `irdy_n_o` is 1 with `irdy_oe_o`=1 for one clock. At the next edge `irdy_oe_o`, `cbe_oe_o` and `frame_oe_o` all drop to 0, together with `busy_o`.
- R9: If `devsel_n_i` is not sampled 0 on any of the 5 edges after the address clock, the fifth such edge ends the transaction with `done_o`=1, `err_o`=1, `rd_last_o`=1 and `rd_data_o`=32'hFFFF_FFFF, and with `frame_n_o` and `irdy_n_o` both 1.
- R10: `busy_o` is 1 from the address clock through the release clock, and it is 1 whenever any bus output enable is 1.
- R11: A `req_valid_i` that is high while `busy_o` is 1 is ignored: no new address clock follows the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Local read request, taken only when idle |
| req_addr_i | input | 32 | Read address |
| req_cmd_i | input | 4 | Bus command placed on C/BE# in the address clock |
| req_be_n_i | input | 4 | Active-low byte enables for the data phases |
| req_burst_i | input | 1 | 1 selects a two-dword burst |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock strobe per returned dword |
| rd_last_o | output | 1 | Marks the final strobe of a transaction |
| err_o | output | 1 | Master abort, qualified by done_o |
| rd_data_o | output | 32 | Captured read data |
| ad_o | output | 32 | AD value to drive |
| ad_oe_o | output | 1 | AD output enable |
| ad_i | input | 32 | Sampled AD bus |
| cbe_n_o | output | 4 | C/BE# value to drive |
| cbe_oe_o | output | 1 | C/BE# output enable |
| frame_n_o | output | 1 | FRAME# value to drive |
| frame_oe_o | output | 1 | FRAME# output enable |
| irdy_n_o | output | 1 | IRDY# value to drive |
| irdy_oe_o | output | 1 | IRDY# output enable |
| devsel_n_i | input | 1 | Sampled DEVSEL# |
| trdy_n_i | input | 1 | Sampled TRDY# |

## Verification
The embedded properties watch four things on every clock: that AD is never driven while IRDY# is active, that busy covers every enabled output, that IRDY# holds through target wait states, and that the release follows an IRDY# deassertion by one clock. They also check that a single read keeps FRAME# low for one clock and that an error strobe always carries all-ones data. Only the bench scenarios can show that the right address, command, byte enables and captured dwords appear in the exact clocks. The same holds for burst FRAME# timing under different wait counts, for the fifth-edge abort timing, and for requests raised while busy leaving no trace.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_REL  = 2'd3
  } rd_state_t;

endpackage

// File: rtl/pci_rd_abort_timer.sv
module pci_rd_abort_timer #(
  parameter int ABORT_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic tick_i,
  input  logic devsel_n_i,
  output logic expire_o
);

  localparam int CNT_W = $clog2(ABORT_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ABORT_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  // counts sampling edges with no claim; a claim freezes the window
  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_i) begin
      if (!devsel_n_i) begin
        seen_q <= 1'b1;
      end else if (!seen_q && cnt_q != LAST_CNT) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign expire_o = tick_i && devsel_n_i && !seen_q && (cnt_q == LAST_CNT);

endmodule

// File: rtl/pci_rd_ctrl.sv
module pci_rd_ctrl
  import pci_rd_pkg::*;
#(
  parameter int MAX_BEATS = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      req_valid_i,
  input  logic      req_burst_i,
  input  logic      devsel_n_i,
  input  logic      trdy_n_i,
  input  logic      expire_i,
  output rd_state_t st_o,
  output logic      accept_o,
  output logic      xfer_o,
  output logic      abort_o,
  output logic      busy_o,
  output logic      done_o,
  output logic      last_o,
  output logic      err_o,
  output logic      frame_n_o,
  output logic      frame_oe_o,
  output logic      irdy_n_o,
  output logic      irdy_oe_o
);

  localparam int BEAT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam logic [BEAT_W-1:0] BURST_LEFT = BEAT_W'(MAX_BEATS - 1);

  rd_state_t         st_q;
  logic [BEAT_W-1:0] beats_q;
  logic              burst_q;
  logic              frame_n_q, frame_oe_q, irdy_n_q, irdy_oe_q;
  logic              busy_q, done_q, last_q, err_q;

  assign accept_o = (st_q == ST_IDLE) && req_valid_i;
  assign xfer_o   = (st_q == ST_DATA) && !irdy_n_q && !trdy_n_i && !devsel_n_i;
  assign abort_o  = (st_q == ST_DATA) && expire_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      beats_q    <= '0;
      burst_q    <= 1'b0;
      frame_n_q  <= 1'b1;
      frame_oe_q <= 1'b0;
      irdy_n_q   <= 1'b1;
      irdy_oe_q  <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      last_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            st_q       <= ST_ADDR;
            frame_n_q  <= 1'b0;
            frame_oe_q <= 1'b1;
            busy_q     <= 1'b1;
            burst_q    <= req_burst_i;
            beats_q    <= req_burst_i ? BURST_LEFT : '0;
          end
        end
        ST_ADDR: begin
          st_q      <= ST_DATA;
          irdy_n_q  <= 1'b0;
          irdy_oe_q <= 1'b1;
          if (beats_q == '0) frame_n_q <= 1'b1;
        end
        ST_DATA: begin
          if (abort_o) begin
            done_q    <= 1'b1;
            last_q    <= 1'b1;
            err_q     <= 1'b1;
            irdy_n_q  <= 1'b1;
            frame_n_q <= 1'b1;
            st_q      <= ST_REL;
          end else if (xfer_o) begin
            done_q <= 1'b1;
            if (beats_q == '0) begin
              last_q   <= 1'b1;
              irdy_n_q <= 1'b1;
              st_q     <= ST_REL;
            end else begin
              beats_q <= beats_q - 1'b1;
              if (beats_q == BEAT_W'(1)) frame_n_q <= 1'b1;
            end
          end
        end
        ST_REL: begin
          st_q       <= ST_IDLE;
          irdy_oe_q  <= 1'b0;
          frame_oe_q <= 1'b0;
          busy_q     <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o       = st_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign last_o     = last_q;
  assign err_o      = err_q;
  assign frame_n_o  = frame_n_q;
  assign frame_oe_o = frame_oe_q;
  assign irdy_n_o   = irdy_n_q;
  assign irdy_oe_o  = irdy_oe_q;

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && req_valid_i) |=> (!frame_n_q && busy_q));

  // R4
  single_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_n_q && !burst_q) |=> frame_n_q);

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!irdy_n_q && trdy_n_i && !devsel_n_i) |=> (!irdy_n_q && !done_q));

endmodule

// File: rtl/pci_rd_dpath.sv
module pci_rd_dpath
  import pci_rd_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_state_t         st_i,
  input  logic              accept_i,
  input  logic              xfer_i,
  input  logic              abort_i,
  input  logic [AD_W-1:0]   req_addr_i,
  input  logic [AD_W/8-1:0] req_cmd_i,
  input  logic [AD_W/8-1:0] req_be_n_i,
  input  logic [AD_W-1:0]   ad_i,
  output logic [AD_W-1:0]   ad_o,
  output logic              ad_oe_o,
  output logic [AD_W/8-1:0] cbe_n_o,
  output logic              cbe_oe_o,
  output logic [AD_W-1:0]   rd_data_o
);

  localparam int CBE_W = AD_W / 8;

  logic [AD_W-1:0]  ad_q, data_q;
  logic             ad_oe_q, cbe_oe_q;
  logic [CBE_W-1:0] cbe_q, be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_q     <= '0;
      ad_oe_q  <= 1'b0;
      cbe_q    <= '1;
      cbe_oe_q <= 1'b0;
      be_q     <= '1;
      data_q   <= '0;
    end else begin
      if (accept_i) begin
        ad_q     <= req_addr_i;
        ad_oe_q  <= 1'b1;
        cbe_q    <= req_cmd_i;
        cbe_oe_q <= 1'b1;
        be_q     <= req_be_n_i;
      end
      if (st_i == ST_ADDR) begin
        ad_oe_q <= 1'b0;
        cbe_q   <= be_q;
      end
      if (xfer_i)  data_q <= ad_i;
      if (abort_i) data_q <= '1;
      if (st_i == ST_REL) begin
        cbe_oe_q <= 1'b0;
        cbe_q    <= '1;
      end
    end
  end

  assign ad_o      = ad_q;
  assign ad_oe_o   = ad_oe_q;
  assign cbe_n_o   = cbe_q;
  assign cbe_oe_o  = cbe_oe_q;
  assign rd_data_o = data_q;

endmodule

// File: rtl/pci_rd_initiator.sv
module pci_rd_initiator
  import pci_rd_pkg::*;
#(
  parameter int AD_W       = 32,
  parameter int ABORT_CLKS = 5,
  parameter int MAX_BEATS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [AD_W-1:0]   req_addr_i,
  input  logic [AD_W/8-1:0] req_cmd_i,
  input  logic [AD_W/8-1:0] req_be_n_i,
  input  logic              req_burst_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_last_o,
  output logic              err_o,
  output logic [AD_W-1:0]   rd_data_o,
  output logic [AD_W-1:0]   ad_o,
  output logic              ad_oe_o,
  input  logic [AD_W-1:0]   ad_i,
  output logic [AD_W/8-1:0] cbe_n_o,
  output logic              cbe_oe_o,
  output logic              frame_n_o,
  output logic              frame_oe_o,
  output logic              irdy_n_o,
  output logic              irdy_oe_o,
  input  logic              devsel_n_i,
  input  logic              trdy_n_i
);

  rd_state_t st;
  logic      accept, xfer, abort, expire;

  pci_rd_ctrl #(.MAX_BEATS(MAX_BEATS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid_i(req_valid_i),
    .req_burst_i(req_burst_i),
    .devsel_n_i (devsel_n_i),
    .trdy_n_i   (trdy_n_i),
    .expire_i   (expire),
    .st_o       (st),
    .accept_o   (accept),
    .xfer_o     (xfer),
    .abort_o    (abort),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .last_o     (rd_last_o),
    .err_o      (err_o),
    .frame_n_o  (frame_n_o),
    .frame_oe_o (frame_oe_o),
    .irdy_n_o   (irdy_n_o),
    .irdy_oe_o  (irdy_oe_o)
  );

  pci_rd_abort_timer #(.ABORT_CLKS(ABORT_CLKS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (st == ST_ADDR),
    .tick_i    (st == ST_DATA),
    .devsel_n_i(devsel_n_i),
    .expire_o  (expire)
  );

  pci_rd_dpath #(.AD_W(AD_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .st_i      (st),
    .accept_i  (accept),
    .xfer_i    (xfer),
    .abort_i   (abort),
    .req_addr_i(req_addr_i),
    .req_cmd_i (req_cmd_i),
    .req_be_n_i(req_be_n_i),
    .ad_i      (ad_i),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .cbe_n_o   (cbe_n_o),
    .cbe_oe_o  (cbe_oe_o),
    .rd_data_o (rd_data_o)
  );

  // R3
  ad_turn_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe_o |-> irdy_n_o);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irdy_n_o) |=> (!irdy_oe_o && !cbe_oe_o && !frame_oe_o && !busy_o));

  // R9
  abort_data_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (rd_data_o == '1));

  // R10
  busy_span_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_oe_o || irdy_oe_o || cbe_oe_o || ad_oe_o) |-> busy_o);

endmodule

// File: tb/pci_rd_initiator_tb.sv
module pci_rd_initiator_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic [3:0]  req_be_n = '1;
  logic        req_burst = 1'b0;
  logic        busy, done, rd_last, err;
  logic [31:0] rd_data, ad_o, ad_i;
  logic        ad_oe, cbe_oe, frame_n, frame_oe, irdy_n, irdy_oe;
  logic [3:0]  cbe_n;
  logic        devsel_n = 1'b1;
  logic        trdy_n = 1'b1;

  int n_checks = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  initial ad_i = '0;

  pci_rd_initiator u_dut (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_cmd_i(req_cmd),
    .req_be_n_i(req_be_n), .req_burst_i(req_burst),
    .busy_o(busy), .done_o(done), .rd_last_o(rd_last), .err_o(err),
    .rd_data_o(rd_data), .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i),
    .cbe_n_o(cbe_n), .cbe_oe_o(cbe_oe), .frame_n_o(frame_n),
    .frame_oe_o(frame_oe), .irdy_n_o(irdy_n), .irdy_oe_o(irdy_oe),
    .devsel_n_i(devsel_n), .trdy_n_i(trdy_n)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic [3:0]  be;
    logic        burst;
    logic [3:0]  waits;
    logic        present;
    logic [31:0] d0;
    logic [31:0] d1;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h1000_0004, 4'h6, 4'h0, 1'b0, 4'd0, 1'b1, 32'hA5A5_0001, 32'h0},
    '{32'h0000_03F8, 4'h2, 4'hE, 1'b0, 4'd3, 1'b1, 32'h0000_0042, 32'h0},
    '{32'h2000_0010, 4'h6, 4'h0, 1'b1, 4'd0, 1'b1, 32'h1111_2222, 32'h3333_4444},
    '{32'h3000_0000, 4'h6, 4'h0, 1'b1, 4'd2, 1'b1, 32'hDEAD_BEEF, 32'hCAFE_F00D},
    '{32'h4000_0000, 4'h6, 4'h3, 1'b0, 4'd0, 1'b0, 32'h0, 32'h0},
    '{32'h5000_0008, 4'h6, 4'h0, 1'b1, 4'd0, 1'b0, 32'h0, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check({req, " busy"}, busy, 0);
    check({req, " done"}, done, 0);
    check({req, " ad_oe"}, ad_oe, 0);
    check({req, " cbe_oe"}, cbe_oe, 0);
    check({req, " frame_oe"}, frame_oe, 0);
    check({req, " irdy_oe"}, irdy_oe, 0);
    check({req, " frame_n"}, frame_n, 1);
    check({req, " irdy_n"}, irdy_n, 1);
  endtask

  task automatic run_txn(input vec_t v, input bit nag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = v.addr; req_cmd = v.cmd;
    req_be_n = v.be; req_burst = v.burst;
    @(negedge clk);
    check("R2 frame_n", frame_n, 0);
    check("R2 ad_oe", ad_oe, 1);
    check("R2 ad", ad_o, v.addr);
    check("R2 cbe cmd", cbe_n, v.cmd);
    check("R10 busy addr", busy, 1);
    if (nag) req_addr = 32'hBAD0_0000;
    else req_valid = 1'b0;
    @(negedge clk);
    check("R3 ad_oe", ad_oe, 0);
    check("R3 cbe be", cbe_n, v.be);
    check("R3 irdy_n", irdy_n, 0);
    check("R4 R7 frame_n turn", frame_n, !v.burst);
    @(negedge clk);
    check("R6 irdy_n turn", irdy_n, 0);
    check("R6 done turn", done, 0);
    if (!v.present) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R9 no early done", done, 0);
      end
      @(negedge clk);
      check("R9 done", done, 1);
      check("R9 err", err, 1);
      check("R9 last", rd_last, 1);
      check("R9 data", rd_data, 32'hFFFF_FFFF);
      check("R9 frame_n", frame_n, 1);
      check("R9 irdy_n", irdy_n, 1);
    end else begin
      devsel_n = 1'b0;
      for (int w = 0; w < int'(v.waits); w++) begin
        trdy_n = 1'b1;
        @(negedge clk);
        check("R6 irdy_n wait", irdy_n, 0);
        check("R6 done wait", done, 0);
      end
      trdy_n = 1'b0; ad_i = v.d0;
      @(negedge clk);
      check("R5 done", done, 1);
      check("R5 data", rd_data, v.d0);
      check("R5 err", err, 0);
      check("R5 R7 last", rd_last, !v.burst);
      if (v.burst) begin
        check("R7 frame_n up", frame_n, 1);
        check("R7 irdy_n low", irdy_n, 0);
        ad_i = v.d1;
        @(negedge clk);
        check("R7 done2", done, 1);
        check("R7 data2", rd_data, v.d1);
        check("R7 last2", rd_last, 1);
      end
      check("R8 irdy_n high", irdy_n, 1);
      check("R8 irdy_oe held", irdy_oe, 1);
      trdy_n = 1'b1; devsel_n = 1'b1;
    end
    req_valid = 1'b0;
    @(negedge clk);
    check_idle("R8 R10 release");
    @(negedge clk);
    check("R11 no new busy", busy, 0);
    check("R11 no new frame", frame_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");

    for (int i = 0; i < 6; i++) run_txn(VECS[i], i == 1);

    // R1: reset in the middle of a transaction
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h7000_0000; req_cmd = 4'h6;
    req_be_n = 4'h0; req_burst = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 pre-reset irdy_n", irdy_n, 0);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1 mid reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 mid reset released");

    // R4: single read after recovery
    run_txn(VECS[0], 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule